// File: doc/BRIEF.md
# Polled Serial Bus Station

This block is the station logic that ties one local processor to one line of a shared serial I/O bus. The line is owned by a central controller that addresses stations one at a time. A station stays silent until it decodes a frame carrying its own address. A poll command then opens a reply window: the station turns on its line driver and forwards, one bit per clock, the serial message that the local processor offers. The reply is closed with a single end-of-message symbol that no data bit can produce, and then the driver is released.

The station guards the line against a faulty processor. A reply is cut off at a hard length limit, and the cut is recorded in a sticky overrun flag. If the processor offers nothing within a timeout, the reply consists of the end-of-message symbol alone, so the controller is never left waiting. Two other commands switch the processor's power on and off. While the processor is unpowered, its data is never taken. Frames that arrive while a reply is in progress are not decoded.

The line uses two-bit symbols: 00 means the driver is off, 01 is a data zero, 10 is a data one and 11 marks the end of a message. The processor side is a valid/ready serial stream with a last-bit flag.

Top module: `bus_station`

## Requirements
- R1: After reset, tx_en_o, tx_sym_o, power_en_o, overrun_o and host_ready_o are all 0.
- R2: A frame is a 1 start bit, then an 8-bit address MSB first, then a 2-bit command MSB first, one bit per clock on bus_rx_i, with the line idle at 0. Command 01 addressed to station_id_i sets power_en_o, and the change shows after the second rising edge that follows the last command bit.
- R3: Command 10 to the station's address clears power_en_o. Command 11 changes nothing and produces no reply.
- R4: A frame whose address differs from station_id_i causes no reply and no power change.
- R5: Command 00 to the station's address is a poll. host_ready_o rises in the cycle after the second edge that follows the last command bit. Each accepted bit is driven in the next cycle as symbol 10 for a one or 01 for a zero. Bits are sent in order, one per cycle.
- R6: A message ends after the bit flagged last, or at the first cycle in the reply without valid data. The next cycle carries symbol 11 for exactly one cycle, after which tx_en_o is 0.
- R7: At most MAX_LEN data symbols are sent. If the processor still offers data after MAX_LEN bits, the reply is closed with symbol 11 and overrun_o is set. A message of exactly MAX_LEN bits does not set overrun_o.
- R8: overrun_o stays set through other frames and commands, and is cleared when the next poll to the station is accepted.
- R9: If no bit is accepted within TIMEOUT cycles of a poll, the reply is the symbol 11 alone, appearing right after those TIMEOUT idle cycles.
- R10: While power_en_o is 0, host_ready_o stays 0, so a poll is answered with symbol 11 alone after the timeout.
- R11: Whenever tx_en_o is 0, tx_sym_o is 00. tx_en_o is 1 only during a reply. Frames received during a reply are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| station_id_i | input | 8 | Strapped station address |
| bus_rx_i | input | 1 | Received line bit from the controller |
| host_valid_i | input | 1 | Processor offers a bit |
| host_bit_i | input | 1 | Offered data bit |
| host_last_i | input | 1 | Offered bit ends the message |
| host_ready_o | output | 1 | Station accepts the offered bit this cycle |
| tx_en_o | output | 1 | Line driver enable |
| tx_sym_o | output | 2 | Line symbol: 00 off, 01 zero, 10 one, 11 end of message |
| power_en_o | output | 1 | Power switch for the local processor |
| overrun_o | output | 1 | Sticky flag: the last reply was cut at the length limit |

## Verification
The properties assume that the processor streams its message without gaps once it starts, and that the controller sends at most one frame at a time. They also assume no frame is in flight while a reply is expected, except in the one directed case that tests frames arriving during a reply. The bench changes the line and the processor signals only on falling clock edges. It sends whole 11-bit frames and gives the processor an unbroken stream, which drops only after the message or when the last flag is set. The length and end-symbol properties therefore see only replies that the controller protocol allows.

// File: rtl/bus_station_pkg.sv
package bus_station_pkg;
  localparam int ADDR_W = 8;
  localparam int CMD_W  = 2;

  typedef enum logic [CMD_W-1:0] {
    CMD_POLL    = 2'b00,
    CMD_PWR_ON  = 2'b01,
    CMD_PWR_OFF = 2'b10,
    CMD_RSVD    = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    SYM_OFF  = 2'b00,
    SYM_ZERO = 2'b01,
    SYM_ONE  = 2'b10,
    SYM_EOM  = 2'b11
  } sym_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_WAIT, ST_SEND, ST_EOM
  } seq_state_e;
endpackage

// File: rtl/bus_station_rx.sv
module bus_station_rx
  import bus_station_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bus_rx_i,
  output logic              frame_vld_o,
  output logic [ADDR_W-1:0] frame_addr_o,
  output cmd_e              frame_cmd_o
);
  localparam int FW  = ADDR_W + CMD_W;
  localparam int CW  = $clog2(FW);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [FW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      sh_q        <= '0;
      frame_vld_o <= 1'b0;
    end else begin
      frame_vld_o <= 1'b0;
      if (!en_i) begin
        busy_q <= 1'b0;
      end else if (!busy_q) begin
        if (bus_rx_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else begin
        sh_q  <= {sh_q[FW-2:0], bus_rx_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(FW-1)) begin
          busy_q      <= 1'b0;
          frame_vld_o <= 1'b1;
        end
      end
    end
  end

  assign frame_addr_o = sh_q[FW-1:CMD_W];
  assign frame_cmd_o  = cmd_e'(sh_q[CMD_W-1:0]);
endmodule

// File: rtl/bus_station_seq.sv
module bus_station_seq
  import bus_station_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int TIMEOUT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       pwr_i,
  input  logic       host_valid_i,
  input  logic       host_bit_i,
  input  logic       host_last_i,
  output logic       host_ready_o,
  output logic       tx_en_o,
  output logic [1:0] tx_sym_o,
  output logic       overrun_o,
  output logic       idle_o
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int TMO_W = $clog2(TIMEOUT + 1);

  seq_state_e       state_q;
  logic [LEN_W-1:0] cnt_q;
  logic [TMO_W-1:0] tmo_q;
  logic             cur_q, last_q;
  logic             at_limit, accept;

  assign at_limit     = (cnt_q == LEN_W'(MAX_LEN));
  assign host_ready_o = pwr_i && ((state_q == ST_WAIT) ||
                                  (state_q == ST_SEND && !last_q && !at_limit));
  assign accept       = host_valid_i && host_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      tmo_q     <= '0;
      cur_q     <= 1'b0;
      last_q    <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_WAIT;
          tmo_q     <= '0;
          overrun_o <= 1'b0;
        end
        ST_WAIT: if (accept) begin
          state_q <= ST_SEND;
          cur_q   <= host_bit_i;
          last_q  <= host_last_i;
          cnt_q   <= LEN_W'(1);
        end else if (tmo_q == TMO_W'(TIMEOUT - 1)) begin
          state_q <= ST_EOM;
        end else begin
          tmo_q <= tmo_q + 1'b1;
        end
        ST_SEND: if (last_q) begin
          state_q <= ST_EOM;
        end else if (host_valid_i) begin
          if (at_limit) begin
            overrun_o <= 1'b1;  // babbling host cut off
            state_q   <= ST_EOM;
          end else begin
            cur_q  <= host_bit_i;
            last_q <= host_last_i;
            cnt_q  <= cnt_q + 1'b1;
          end
        end else begin
          state_q <= ST_EOM;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tx_en_o  = (state_q == ST_SEND) || (state_q == ST_EOM);
    tx_sym_o = SYM_OFF;
    if (state_q == ST_EOM)       tx_sym_o = SYM_EOM;
    else if (state_q == ST_SEND) tx_sym_o = cur_q ? SYM_ONE : SYM_ZERO;
  end

  assign idle_o = (state_q == ST_IDLE);
endmodule

// File: rtl/bus_station.sv
module bus_station
  import bus_station_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int TIMEOUT = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  station_id_i,
  input  logic        bus_rx_i,
  input  logic        host_valid_i,
  input  logic        host_bit_i,
  input  logic        host_last_i,
  output logic        host_ready_o,
  output logic        tx_en_o,
  output logic [1:0]  tx_sym_o,
  output logic        power_en_o,
  output logic        overrun_o
);
  logic              seq_idle, frame_vld, hit;
  logic [ADDR_W-1:0] frame_addr;
  cmd_e              frame_cmd;

  bus_station_rx u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (seq_idle),
    .bus_rx_i     (bus_rx_i),
    .frame_vld_o  (frame_vld),
    .frame_addr_o (frame_addr),
    .frame_cmd_o  (frame_cmd)
  );

  assign hit = frame_vld && (frame_addr == station_id_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            power_en_o <= 1'b0;
    else if (hit && frame_cmd == CMD_PWR_ON)  power_en_o <= 1'b1;
    else if (hit && frame_cmd == CMD_PWR_OFF) power_en_o <= 1'b0;
  end

  bus_station_seq #(.MAX_LEN(MAX_LEN), .TIMEOUT(TIMEOUT)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (hit && frame_cmd == CMD_POLL),
    .pwr_i        (power_en_o),
    .host_valid_i (host_valid_i),
    .host_bit_i   (host_bit_i),
    .host_last_i  (host_last_i),
    .host_ready_o (host_ready_o),
    .tx_en_o      (tx_en_o),
    .tx_sym_o     (tx_sym_o),
    .overrun_o    (overrun_o),
    .idle_o       (seq_idle)
  );
endmodule

// File: rtl/bus_station_chk.sv
module bus_station_chk #(
  parameter int MAX_LEN = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_en_o,
  input logic [1:0] tx_sym_o,
  input logic       host_ready_o,
  input logic       power_en_o,
  input logic       overrun_o
);
  localparam int RUN_W = $clog2(MAX_LEN + 2);
  logic             is_data;
  logic [RUN_W-1:0] run_q;

  assign is_data = tx_en_o && (tx_sym_o[1] ^ tx_sym_o[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (is_data) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  p_passive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> tx_sym_o == 2'b00);

  p_eom_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && tx_sym_o == 2'b11) |=> !tx_en_o);

  p_data_then_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_data |=> tx_en_o);

  p_max_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_data |-> run_q < RUN_W'(MAX_LEN));

  p_overrun_at_eom_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> (tx_en_o && tx_sym_o == 2'b11));

  p_unpowered_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !power_en_o |-> !host_ready_o);
endmodule

bind bus_station bus_station_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_en_o      (tx_en_o),
  .tx_sym_o     (tx_sym_o),
  .host_ready_o (host_ready_o),
  .power_en_o   (power_en_o),
  .overrun_o    (overrun_o)
);

// File: tb/bus_station_test.sv
module bus_station_test;
  localparam int MAX_LEN = 8;
  localparam int TIMEOUT = 16;
  localparam logic [7:0] OWN = 8'hA5;
  localparam int NV = 13;
  // {addr[32:25], cmd[24:23], len[22:18], last[17], host_en[16], pattern[15:0]}
  localparam logic [32:0] VEC [NV] = '{
    {8'hA5, 2'b01, 5'd0,  1'b0, 1'b0, 16'h0000},  // R2 power on
    {8'hA5, 2'b00, 5'd5,  1'b1, 1'b1, 16'h0016},  // R5 R6 last flag
    {8'h3C, 2'b00, 5'd4,  1'b0, 1'b1, 16'h000F},  // R4 other address
    {8'hA5, 2'b00, 5'd6,  1'b0, 1'b1, 16'h0019},  // R6 gap ends
    {8'hA5, 2'b00, 5'd8,  1'b1, 1'b1, 16'h00C3},  // R7 exactly max
    {8'hA5, 2'b00, 5'd12, 1'b0, 1'b1, 16'h0A5A},  // R7 overrun
    {8'hA5, 2'b00, 5'd0,  1'b0, 1'b0, 16'h0000},  // R9 R8 timeout, clears
    {8'hA5, 2'b11, 5'd0,  1'b0, 1'b1, 16'h0000},  // R3 reserved
    {8'hA5, 2'b10, 5'd0,  1'b0, 1'b0, 16'h0000},  // R3 power off
    {8'hA5, 2'b00, 5'd4,  1'b1, 1'b1, 16'h0005},  // R10 unpowered poll
    {8'h5A, 2'b01, 5'd0,  1'b0, 1'b0, 16'h0000},  // R4 other address
    {8'hA5, 2'b01, 5'd0,  1'b0, 1'b0, 16'h0000},  // R2 power on
    {8'hA5, 2'b00, 5'd1,  1'b1, 1'b1, 16'h0001}   // R5 single bit
  };

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b0;
  logic host_en = 1'b0, use_last = 1'b0, idx_clr = 1'b0;
  logic [4:0]  msg_len = '0, idx = '0;
  logic [15:0] msg_pat = '0;
  logic host_valid, host_bit, host_last, host_ready, tx_en, pwr, ovr;
  logic [1:0] tx_sym;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign host_valid = host_en && (idx < msg_len);
  assign host_bit   = msg_pat[idx[3:0]];
  assign host_last  = use_last && (idx == msg_len - 5'd1);

  always @(posedge clk)
    if (idx_clr) idx <= '0;
    else if (host_valid && host_ready) idx <= idx + 5'd1;

  bus_station #(.MAX_LEN(MAX_LEN), .TIMEOUT(TIMEOUT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .station_id_i(OWN), .bus_rx_i(rx),
    .host_valid_i(host_valid), .host_bit_i(host_bit), .host_last_i(host_last),
    .host_ready_o(host_ready), .tx_en_o(tx_en), .tx_sym_o(tx_sym),
    .power_en_o(pwr), .overrun_o(ovr));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] a, input logic [1:0] c);
    logic [10:0] f;
    f = {1'b1, a, c};
    idx_clr = 1'b1;
    for (int i = 10; i >= 0; i--) begin
      @(negedge clk);
      rx = f[i];
    end
    @(negedge clk);
    rx = 1'b0;
    idx_clr = 1'b0;
  endtask

  task automatic collect(output bit rep, output int nd, output int gp,
                         output logic [15:0] bits, output bit eom_ok,
                         output bit rel_ok);
    rep = 0; nd = 0; gp = 0; bits = '0; eom_ok = 0; rel_ok = 0;
    for (int i = 0; i < TIMEOUT + 8; i++) begin
      @(negedge clk);
      if (tx_en) begin
        rep = 1;
        break;
      end
      gp++;
    end
    if (rep) begin
      for (int k = 0; k < 40; k++) begin
        if (!tx_en || tx_sym == 2'b11) break;
        if (nd < 16) bits[nd] = (tx_sym == 2'b10);
        nd++;
        @(negedge clk);
      end
      eom_ok = tx_en && (tx_sym == 2'b11);
      @(negedge clk);
      rel_ok = !tx_en && (tx_sym == 2'b00);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit rep, eom_ok, rel_ok, exp_pwr, exp_ovr;
    int nd, gp, n_exp;
    logic [15:0] bits, mask;

    repeat (3) @(negedge clk);
    chk(!tx_en && tx_sym == 2'b00 && !pwr && !ovr && !host_ready, "R1",
        "outputs in reset", {tx_en, tx_sym, pwr, ovr, host_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!tx_en && !pwr && !ovr && !host_ready, "R1", "outputs after reset",
        {tx_en, pwr, ovr, host_ready}, 0);

    exp_pwr = 0; exp_ovr = 0;
    for (int v = 0; v < NV; v++) begin
      logic [7:0] a; logic [1:0] c; bit poll;
      a = VEC[v][32:25]; c = VEC[v][24:23];
      msg_len = VEC[v][22:18]; use_last = VEC[v][17];
      host_en = VEC[v][16]; msg_pat = VEC[v][15:0];
      poll = (a == OWN) && (c == 2'b00);
      if (a == OWN && c == 2'b01) exp_pwr = 1;
      if (a == OWN && c == 2'b10) exp_pwr = 0;
      n_exp = 0;
      if (poll) begin
        exp_ovr = 0;
        if (exp_pwr && host_en)
          n_exp = (msg_len > MAX_LEN) ? MAX_LEN : int'(msg_len);
        if (exp_pwr && host_en && msg_len > MAX_LEN) exp_ovr = 1;
      end
      send_frame(a, c);
      collect(rep, nd, gp, bits, eom_ok, rel_ok);
      chk(rep == poll, "R4 R3", $sformatf("vector %0d reply present", v), rep, poll);
      if (poll && rep) begin
        mask = 16'((32'd1 << n_exp) - 1);
        chk(nd == n_exp, "R7 R5", $sformatf("vector %0d data count", v), nd, n_exp);
        chk(bits == (msg_pat & mask), "R5", $sformatf("vector %0d data bits", v),
            bits, msg_pat & mask);
        chk(eom_ok && rel_ok, "R6", $sformatf("vector %0d end symbol then release", v),
            {eom_ok, rel_ok}, 3);
        chk(gp == ((n_exp == 0) ? TIMEOUT : 1), "R9 R10",
            $sformatf("vector %0d idle cycles before reply", v), gp,
            (n_exp == 0) ? TIMEOUT : 1);
      end
      chk(ovr == exp_ovr, "R7 R8", $sformatf("vector %0d overrun", v), ovr, exp_ovr);
      chk(pwr == exp_pwr, "R2 R3", $sformatf("vector %0d power", v), pwr, exp_pwr);
    end

    // R8: overrun survives unrelated frames and commands
    host_en = 1; use_last = 0; msg_len = 5'd12; msg_pat = 16'h0FFF;
    send_frame(OWN, 2'b00);
    collect(rep, nd, gp, bits, eom_ok, rel_ok);
    chk(ovr, "R7", "overrun after long message", ovr, 1);
    send_frame(8'h3C, 2'b00);
    collect(rep, nd, gp, bits, eom_ok, rel_ok);
    send_frame(OWN, 2'b01);
    collect(rep, nd, gp, bits, eom_ok, rel_ok);
    chk(ovr, "R8", "overrun sticky across frames", ovr, 1);

    // R11: frame during a reply is ignored; R8: poll clears overrun
    host_en = 0;
    send_frame(OWN, 2'b00);
    @(negedge clk);
    chk(!ovr, "R8", "overrun cleared by poll", ovr, 0);
    chk(host_ready, "R5", "ready one cycle after poll", host_ready, 1);
    send_frame(OWN, 2'b10);
    collect(rep, nd, gp, bits, eom_ok, rel_ok);
    chk(rep && nd == 0 && eom_ok, "R11", "reply is end symbol only", nd, 0);
    chk(pwr, "R11", "power-off during reply ignored", pwr, 1);
    repeat (3) @(negedge clk);
    chk(!tx_en && tx_sym == 2'b00, "R11", "line passive after reply", tx_sym, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule